// File: doc/BRIEF.md
# Credit-Throttled Bitstream Block Sender

This block moves a stream of 32-bit configuration words into a single data register of a receiver, using a simple request/acknowledge register master port. The words are grouped into fixed-size blocks. In credit mode, the block reads the receiver's 8-bit credit register before the first word of every block. It releases the block only when that credit value differs from the low byte of its own count of sent blocks.

While it waits for credit, it reads the receiver's status register on every pass. It gives up with a configuration error when the error bit is set. It gives up with a timeout after a fixed number of unanswered credit polls, with a fixed number of idle cycles between polls. Optional checking also samples the error bit after every fixed span of data words and once after the final word.

The final word of a transfer may carry fewer than four valid bytes; its unused upper bytes are written as zero. A legacy build treats every word as its own block and never reads credit.

A controller pulses `start` to clear the counters and begin a transfer. It then reads `done`, `err_cfg` and `err_tmo`, which stay put until the next `start`.

Top module: `cred_blk_sender`

## Requirements
- R1: After reset, `s_ready`, `m_req`, `done`, `err_cfg` and `err_tmo` are low and `blk_cnt` is zero; nothing happens until `start` is pulsed.
- R2: Each accepted input word produces exactly one write (`m_we`=1) to address DATA_ADDR (default 0x28), in input order. `s_ready` is high only in the cycle where that write is acknowledged, and a request holds its address until `m_ack`.
- R3: When `s_last`=1, `s_bytes` gives the valid byte count (1, 2 or 3 keep that many low bytes and zero the rest; 0 means all four bytes are valid). On words without `s_last`, `s_bytes` is ignored.
- R4: In credit mode, before the first word of each block of WORDS_PER_BLK words, the block reads address CREDIT_ADDR (default 0x49). It sends the block only when read-data bits [7:0] differ from `blk_cnt[7:0]`; until then no data write is issued.
- R5: `blk_cnt` rises by one for every completed block, where a transfer's short final block counts as a block. `start` clears it to zero.
- R6: While credit is withheld, each failed credit read is followed by a read of STATUS_ADDR (default 0x1C). If bit ERR_BIT (default 19) is set, the block stops with `err_cfg`=1 and issues no further writes.
- R7: Between failed polls the port stays idle for POLL_GAP cycles. After POLL_LIMIT failed credit reads the block stops with `err_tmo`=1 and no data written.
- R8: With `chk_en`=1, the status register is read after every CHK_WORDS data words and after the final word, and a set error bit stops the block with `err_cfg`=1. With `chk_en`=0 and credit available, no status read is made.
- R9: `done` goes high in the cycle after the acknowledge of the transfer's final access (the last data write, or the end check when `chk_en`=1). It stays high until `start`, and is never high together with an error flag.
- R10: With CREDIT_MODE=0, every word is its own block, no credit read is ever made, and `blk_cnt` equals the number of words sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer; clears counters and flags |
| chk_en | input | 1 | Enable periodic and final error checks |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted this cycle |
| s_data | input | 32 | Input word |
| s_last | input | 1 | Final word of the transfer |
| s_bytes | input | 2 | Valid bytes in the final word (0 means 4) |
| m_req | output | 1 | Register access request |
| m_we | output | 1 | 1 for write, 0 for read |
| m_addr | output | ADDR_W | Register address |
| m_wdata | output | 32 | Write data |
| m_ack | input | 1 | Access acknowledge |
| m_rdata | input | 32 | Read data, valid with `m_ack` |
| blk_cnt | output | CNT_W | Blocks sent since `start` |
| done | output | 1 | Transfer finished cleanly |
| err_cfg | output | 1 | Stopped on receiver error bit |
| err_tmo | output | 1 | Stopped on credit timeout |

## Verification
The bench builds the credit instance with WORDS_PER_BLK=4, CHK_WORDS=4, POLL_GAP=3 and POLL_LIMIT=5, so multi-block transfers, short final blocks, mid-stream checks and a full timeout all fit in a few dozen cycles. The idle gap count and poll count at timeout can then be checked exactly. A second instance with CREDIT_MODE=0 runs beside it with its credit register held equal to the counter, which would stall a credit build and so shows that no credit read gates the legacy path.

// File: rtl/cred_blk_sender.sv
module cred_blk_sender #(
  parameter int ADDR_W        = 8,
  parameter int CNT_W         = 16,
  parameter int WORDS_PER_BLK = 1024,
  parameter int CREDIT_MODE   = 1,
  parameter int CHK_WORDS     = 1024,
  parameter int POLL_GAP      = 2500,
  parameter int POLL_LIMIT    = 4000,
  parameter int ERR_BIT       = 19,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 'h28,
  parameter logic [ADDR_W-1:0] CREDIT_ADDR = 'h49,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chk_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [31:0]       s_data,
  input  logic              s_last,
  input  logic [1:0]        s_bytes,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [31:0]       m_wdata,
  input  logic              m_ack,
  input  logic [31:0]       m_rdata,
  output logic [CNT_W-1:0]  blk_cnt,
  output logic              done,
  output logic              err_cfg,
  output logic              err_tmo
);
  localparam int BLK_WORDS = (CREDIT_MODE != 0) ? WORDS_PER_BLK : 1;
  localparam int WW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
  localparam int KW = (CHK_WORDS > 1) ? $clog2(CHK_WORDS) : 1;
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam logic [WW-1:0] W_MAX  = WW'(BLK_WORDS - 1);
  localparam logic [KW-1:0] K_MAX  = KW'(CHK_WORDS - 1);
  localparam logic [PW-1:0] PL_MAX = PW'(POLL_LIMIT - 1);
  localparam logic [GW-1:0] G_MAX  = GW'(POLL_GAP - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_CRD, S_STA, S_GAP, S_WR, S_CHK, S_DONE, S_FAIL
  } st_t;

  st_t           st;
  logic [WW-1:0] wcnt;
  logic [KW-1:0] kcnt;
  logic [PW-1:0] poll_n;
  logic [GW-1:0] gap_n;
  logic          last_q;
  logic          blk_end;
  logic          has_credit;
  logic          rd_err;
  logic          unused_rd;

  assign blk_end    = s_last || (wcnt == W_MAX);
  assign has_credit = (m_rdata[7:0] != blk_cnt[7:0]);
  assign rd_err     = m_rdata[ERR_BIT];
  assign unused_rd  = ^m_rdata;

  assign m_req   = (st == S_CRD) || (st == S_STA) || (st == S_WR) || (st == S_CHK);
  assign m_we    = (st == S_WR);
  assign s_ready = (st == S_WR) && m_ack;
  assign done    = (st == S_DONE);

  always_comb begin
    case (st)
      S_CRD:        m_addr = CREDIT_ADDR;
      S_STA, S_CHK: m_addr = STATUS_ADDR;
      default:      m_addr = DATA_ADDR;
    endcase
  end

  always_comb begin
    m_wdata = s_data;
    if (s_last) begin
      case (s_bytes)
        2'd1:    m_wdata = {24'h0, s_data[7:0]};
        2'd2:    m_wdata = {16'h0, s_data[15:0]};
        2'd3:    m_wdata = {8'h0, s_data[23:0]};
        default: m_wdata = s_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wcnt    <= '0;
      kcnt    <= '0;
      poll_n  <= '0;
      gap_n   <= '0;
      last_q  <= 1'b0;
      blk_cnt <= '0;
      err_cfg <= 1'b0;
      err_tmo <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL: begin
          if (start) begin
            st      <= S_WAIT;
            wcnt    <= '0;
            kcnt    <= '0;
            last_q  <= 1'b0;
            blk_cnt <= '0;
            err_cfg <= 1'b0;
            err_tmo <= 1'b0;
          end
        end
        S_WAIT: begin
          poll_n <= '0;
          if (s_valid)
            st <= (CREDIT_MODE != 0 && wcnt == '0) ? S_CRD : S_WR;
        end
        S_CRD: begin
          if (m_ack) st <= has_credit ? S_WR : S_STA;
        end
        S_STA: begin
          if (m_ack) begin
            if (rd_err) begin
              err_cfg <= 1'b1;
              st      <= S_FAIL;
            end else if (poll_n == PL_MAX) begin
              err_tmo <= 1'b1;
              st      <= S_FAIL;
            end else begin
              poll_n <= poll_n + 1'b1;
              gap_n  <= '0;
              st     <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (gap_n == G_MAX) st <= S_CRD;
          else gap_n <= gap_n + 1'b1;
        end
        S_WR: begin
          if (m_ack) begin
            wcnt   <= blk_end ? '0 : wcnt + 1'b1;
            kcnt   <= (kcnt == K_MAX) ? '0 : kcnt + 1'b1;
            last_q <= s_last;
            if (blk_end) blk_cnt <= blk_cnt + 1'b1;
            if (s_last)
              st <= chk_en ? S_CHK : S_DONE;
            else if (chk_en && kcnt == K_MAX)
              st <= S_CHK;
            else
              st <= S_WAIT;
          end
        end
        S_CHK: begin
          if (m_ack) begin
            if (rd_err) begin
              err_cfg <= 1'b1;
              st      <= S_FAIL;
            end else begin
              st <= last_q ? S_DONE : S_WAIT;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cred_blk_sender_chk.sv
module cred_blk_sender_chk #(
  parameter int ADDR_W      = 8,
  parameter int CNT_W       = 16,
  parameter int CREDIT_MODE = 1,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 'h28,
  parameter logic [ADDR_W-1:0] CREDIT_ADDR = 'h49
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_last,
  input logic [1:0]        s_bytes,
  input logic              m_req,
  input logic              m_we,
  input logic [ADDR_W-1:0] m_addr,
  input logic [31:0]       m_wdata,
  input logic              m_ack,
  input logic [CNT_W-1:0]  blk_cnt,
  input logic              done,
  input logic              err_cfg,
  input logic              err_tmo
);
  assert_ready_in_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (m_req && m_ack && m_we && m_addr == DATA_ADDR));

  assert_write_has_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we) |-> s_valid);

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

  assert_tail_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we && s_last && s_bytes != 2'd0) |-> ((m_wdata >> {s_bytes, 3'b000}) == 32'd0));

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_cnt != $past(blk_cnt)) |-> (blk_cnt == $past(blk_cnt) + 1'b1 || blk_cnt == '0));

  assert_no_write_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cfg || err_tmo) |-> !(m_req && m_we));

  assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && (err_cfg || err_tmo)));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_no_credit_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> (CREDIT_MODE != 0 || m_addr != CREDIT_ADDR));
endmodule

bind cred_blk_sender cred_blk_sender_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CREDIT_MODE(CREDIT_MODE),
  .DATA_ADDR(DATA_ADDR), .CREDIT_ADDR(CREDIT_ADDR)
) u_chk (.*);

// File: tb/test_cred_blk_sender.sv
`timescale 1ns/1ps
module tb_reg_slave #(
  parameter logic [7:0] DAT_A = 8'h28,
  parameter logic [7:0] CRD_A = 8'h49,
  parameter logic [7:0] STA_A = 8'h1C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  input  logic [7:0]  crd,
  input  logic        err
);
  int n_wr = 0, n_crd = 0, n_sta = 0, n_badwr = 0;
  logic [31:0] wlog [0:63];

  always_ff @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else ack <= req && !ack;
  end

  always @(posedge clk) begin
    if (rst_n && req && ack) begin
      if (we) begin
        if (addr == DAT_A) begin
          wlog[n_wr % 64] = wdata;
          n_wr++;
        end else n_badwr++;
      end else if (addr == CRD_A) n_crd++;
      else if (addr == STA_A) n_sta++;
    end
  end

  always_comb begin
    if (addr == CRD_A) rdata = {24'h0, crd};
    else if (addr == STA_A) rdata = {12'h0, err, 19'h0};
    else rdata = 32'h0;
  end
endmodule

module test_cred_blk_sender;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n = 1'b0;

  int total = 0, bad = 0;

  logic start = 0, chk_en = 0, s_valid = 0, s_last = 0;
  logic [31:0] s_data = 0;
  logic [1:0]  s_bytes = 0;
  logic s_ready, m_req, m_we, m_ack, done, err_cfg, err_tmo;
  logic [7:0]  m_addr;
  logic [31:0] m_wdata, m_rdata;
  logic [15:0] blk_cnt;
  logic [7:0]  crd = 8'hFF;
  logic        err_bit = 0;

  logic g_start = 0, g_valid = 0, g_last = 0;
  logic [31:0] g_data = 0;
  logic [1:0]  g_bytes = 0;
  logic g_ready, g_req, g_we, g_ack, g_done, g_ecfg, g_etmo;
  logic [7:0]  g_addr;
  logic [31:0] g_wdata, g_rdata;
  logic [15:0] g_blk_cnt;

  cred_blk_sender #(.WORDS_PER_BLK(4), .CHK_WORDS(4), .POLL_GAP(3), .POLL_LIMIT(5))
  i_cred_blk_sender (
    .clk(clk), .rst_n(rst_n), .start(start), .chk_en(chk_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last), .s_bytes(s_bytes),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata),
    .blk_cnt(blk_cnt), .done(done), .err_cfg(err_cfg), .err_tmo(err_tmo));

  tb_reg_slave sl (.clk(clk), .rst_n(rst_n), .req(m_req), .we(m_we), .addr(m_addr),
    .wdata(m_wdata), .ack(m_ack), .rdata(m_rdata), .crd(crd), .err(err_bit));

  cred_blk_sender #(.WORDS_PER_BLK(4), .CHK_WORDS(4), .POLL_GAP(3), .POLL_LIMIT(5), .CREDIT_MODE(0))
  i_cred_blk_sender_leg (
    .clk(clk), .rst_n(rst_n), .start(g_start), .chk_en(1'b0),
    .s_valid(g_valid), .s_ready(g_ready), .s_data(g_data), .s_last(g_last), .s_bytes(g_bytes),
    .m_req(g_req), .m_we(g_we), .m_addr(g_addr), .m_wdata(g_wdata), .m_ack(g_ack), .m_rdata(g_rdata),
    .blk_cnt(g_blk_cnt), .done(g_done), .err_cfg(g_ecfg), .err_tmo(g_etmo));

  tb_reg_slave gsl (.clk(clk), .rst_n(rst_n), .req(g_req), .we(g_we), .addr(g_addr),
    .wdata(g_wdata), .ack(g_ack), .rdata(g_rdata), .crd(8'h00), .err(1'b0));

  // {data[66:35], last[34], bytes[33:32], expected write[31:0]}
  localparam logic [66:0] VEC [0:8] = '{
    {32'h11111111, 1'b0, 2'd0, 32'h11111111},
    {32'h22222222, 1'b0, 2'd0, 32'h22222222},
    {32'h33333333, 1'b0, 2'd1, 32'h33333333},
    {32'h44444444, 1'b0, 2'd0, 32'h44444444},
    {32'h55555555, 1'b0, 2'd2, 32'h55555555},
    {32'hA1B2C3D4, 1'b1, 2'd3, 32'h00B2C3D4},
    {32'hCAFEF00D, 1'b1, 2'd1, 32'h0000000D},
    {32'h12345678, 1'b1, 2'd2, 32'h00005678},
    {32'hDEADBEEF, 1'b1, 2'd0, 32'hDEADBEEF}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input bit leg);
    if (leg) g_start = 1; else start = 1;
    @(negedge clk);
    g_start = 0; start = 0;
  endtask

  task automatic push(input bit leg, input logic [31:0] d, input bit l, input logic [1:0] b,
                      output bit dn_pre);
    if (!leg) begin
      s_valid = 1; s_data = d; s_last = l; s_bytes = b;
      while (!s_ready) @(negedge clk);
      dn_pre = done;
      @(negedge clk);
      s_valid = 0; s_last = 0;
    end else begin
      g_valid = 1; g_data = d; g_last = l; g_bytes = b;
      while (!g_ready) @(negedge clk);
      dn_pre = g_done;
      @(negedge clk);
      g_valid = 0; g_last = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit dn;
    int w0, c0, st0, nw, zeros;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 s_ready", s_ready, 0);
    chk("R1 m_req", m_req, 0);
    chk("R1 done", done, 0);
    chk("R1 blk_cnt", blk_cnt, 0);
    chk("R1 errors", {err_cfg, err_tmo}, 0);
    repeat (3) @(negedge clk);
    chk("R1 idle without start", m_req, 0);

    // table walk: credit available, no checking
    w0 = sl.n_wr; c0 = sl.n_crd; st0 = sl.n_sta; nw = 0;
    for (int i = 0; i < 9; i++) begin
      if (i == 0 || VEC[i-1][34]) begin do_start(0); nw = 0; end
      push(0, VEC[i][66:35], VEC[i][34], VEC[i][33:32], dn);
      nw++;
      if (VEC[i][34]) begin
        chk("R9 done low before last ack", dn, 0);
        chk("R9 done after last ack", done, 1);
        chk("R5 blocks per transfer", blk_cnt, (nw + 3) / 4);
      end
    end
    for (int i = 0; i < 9; i++)
      chk($sformatf("R2/R3 write data %0d", i), sl.wlog[(w0 + i) % 64], VEC[i][31:0]);
    chk("R2 write count", sl.n_wr - w0, 9);
    chk("R2 write address", sl.n_badwr, 0);
    chk("R4 credit reads per block", sl.n_crd - c0, 5);
    chk("R8 no status reads when disabled", sl.n_sta - st0, 0);

    // start clears, credit stall then release
    do_start(0);
    chk("R5 start clears count", blk_cnt, 0);
    crd = 8'h00;
    w0 = sl.n_wr; c0 = sl.n_crd;
    fork
      push(0, 32'h0BADF00D, 1, 2'd0, dn);
      begin
        repeat (10) @(negedge clk);
        chk("R4 no write while credit equal", sl.n_wr - w0, 0);
        chk("R4 credit polled", (sl.n_crd - c0) >= 1, 1);
        crd = 8'h01;
      end
    join
    chk("R4 write after credit", sl.n_wr - w0, 1);
    chk("R4 data after credit", sl.wlog[w0 % 64], 32'h0BADF00D);
    chk("R9 done after stall", done, 1);

    // credit timeout
    do_start(0);
    crd = 8'h00;
    w0 = sl.n_wr; c0 = sl.n_crd; st0 = sl.n_sta;
    zeros = 0; seen = 0;
    s_valid = 1; s_data = 32'h01020304; s_last = 1; s_bytes = 0;
    for (int k = 0; k < 200 && !err_tmo; k++) begin
      @(negedge clk);
      if (m_req) seen = 1;
      else if (seen && !err_tmo) zeros++;
    end
    s_valid = 0; s_last = 0;
    chk("R7 timeout flag", err_tmo, 1);
    chk("R7 idle gap cycles", zeros, 12);
    chk("R7 credit polls", sl.n_crd - c0, 5);
    chk("R6 status read per poll", sl.n_sta - st0, 5);
    chk("R7 no data write", sl.n_wr - w0, 0);
    chk("R9 no done on timeout", done, 0);

    // error bit while waiting
    do_start(0);
    chk("R7 start clears timeout", err_tmo, 0);
    err_bit = 1;
    w0 = sl.n_wr; st0 = sl.n_sta;
    s_valid = 1; s_last = 1;
    for (int k = 0; k < 50 && !err_cfg; k++) @(negedge clk);
    s_valid = 0; s_last = 0;
    chk("R6 config error", err_cfg, 1);
    chk("R6 no timeout", err_tmo, 0);
    chk("R6 one status read", sl.n_sta - st0, 1);
    chk("R6 no data write", sl.n_wr - w0, 0);
    err_bit = 0;

    // optional checking, clean
    crd = 8'hFF; chk_en = 1;
    do_start(0);
    st0 = sl.n_sta; w0 = sl.n_wr;
    for (int i = 0; i < 9; i++) push(0, 32'h100 + i, i == 8, 2'd0, dn);
    chk("R9 done waits for end check", done, 0);
    repeat (2) @(negedge clk);
    chk("R9 done after end check", done, 1);
    chk("R8 status reads", sl.n_sta - st0, 3);
    chk("R5 blocks with checking", blk_cnt, 3);

    // optional checking, error at first span
    do_start(0);
    err_bit = 1;
    st0 = sl.n_sta; w0 = sl.n_wr;
    for (int i = 0; i < 4; i++) push(0, 32'h200 + i, 0, 2'd0, dn);
    repeat (3) @(negedge clk);
    chk("R8 error at span check", err_cfg, 1);
    chk("R8 writes before abort", sl.n_wr - w0, 4);
    chk("R8 one span check", sl.n_sta - st0, 1);
    chk("R5 count at abort", blk_cnt, 1);
    err_bit = 0; chk_en = 0;

    // legacy build
    do_start(1);
    push(1, 32'h0F0F0F0F, 0, 2'd0, dn);
    push(1, 32'hF0F0F0F0, 0, 2'd0, dn);
    push(1, 32'h89ABCDEF, 1, 2'd2, dn);
    chk("R10 legacy writes", gsl.n_wr, 3);
    chk("R10 legacy no credit reads", gsl.n_crd, 0);
    chk("R10 legacy block count", g_blk_cnt, 3);
    chk("R10 legacy done", g_done, 1);
    chk("R3 legacy tail mask", gsl.wlog[2], 32'h0000CDEF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule